// File: doc/BRIEF.md
# NAND Copy-Back Command Sequencer

This block is a host-side controller that copies one page of a raw NAND flash device into another page inside the device. The page data never crosses the bus. A single start pulse carries a source row address and a target row address. The block then runs the whole operation on an 8-bit command/address bus with a ready/busy input, in this order:

1. It loads the source page into the device's page buffer and waits out the read busy time.
2. It issues the copy-back program command, the target address and the confirm command, and waits out the program busy time.
3. It reads the status byte and ends with a one-cycle result pulse.

Before any bus cycle, the block compares the plane/die-select row bits of the two addresses. The set of bits compared depends on device density. If the addresses disagree in those bits, the request is refused at once and no bus cycle is driven.

After every copy that succeeds, the block records the erase block of the target. A partial-page program check that later hits that block is flagged until the host reports an erase of it.

The bus is write-only on the data output side. `dq_out` and `dq_oe` drive the pads, and `dq_in` returns the pad value. Row bit k of an address is device address bit A(k+9). The single column byte is always sent as zero, because the whole page is copied.

Top module: `nand_copyback_seq`

## Requirements
- R1: While reset is held, and after it is released with no request, `ce_n`, `we_n` and `re_n` are 1, `cle`, `ale`, `done` and `seq_busy` are 0.
- R2: The first phase is the command byte 00h, followed by exactly four address bytes: the column byte 00h, then source row bits [7:0], [15:8] and [23:16].
- R3: After the first phase, no further bus cycle is driven until ready/busy has returned high. No read strobe occurs between the two phases.
- R4: The second phase is the command byte 8Ah, then the column byte 00h, then target row bits [7:0], [15:8] and [23:16], then the confirm byte 10h.
- R5: After ready/busy returns high following the confirm byte, the block writes command 70h and then makes exactly one read strobe. `done_status` equals the byte read, and `done_fail` equals bit 0 of that byte.
- R6: Each command byte is written with `cle`=1 and `ale`=0. Each address byte is written with `ale`=1 and `cle`=0. Every write pulse holds `we_n` low for exactly STROBE_LOW clocks. `ce_n` stays low from the first byte until the result, and rises exactly once per operation.
- R7: The density selects the compared row bits: 128M uses bit 14, 256M bit 15, 512M bit 16, dual-die 512M bits 15 and 16, dual-die 1G bits 16 and 17 (default). If source and target differ in any compared bit, no bus cycle is driven, `ce_n` stays high, and `done` with `done_mismatch` follows within two clocks of the start.
- R8: If either busy wait lasts longer than BUSY_TIMEOUT clocks, the block ends with `done_timeout`=1 and `done_fail`=0. It drives no further bus cycle and releases `ce_n`.
- R9: Each request yields exactly one `done` pulse, one clock wide, with at most one of `done_fail`, `done_mismatch` and `done_timeout` set.
- R10: A start pulse while `seq_busy` is 1 is ignored. The running copy keeps its addresses, and no second result follows.
- R11: After a successful copy, `pp_locked` is 1 whenever `pp_check` is 1 and `pp_row` lies in the same erase block as the target, meaning rows equal above bit PAGE_BITS-1. For other blocks it is 0.
- R12: An `erase_note` pulse clears the lock of the erase block containing `erase_row`, and leaves other locks in place. A copy that fails, is refused or times out records no lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse for one copy |
| src_row | input | 24 | Source page row address |
| tgt_row | input | 24 | Target page row address |
| seq_busy | output | 1 | High from acceptance to the result pulse |
| done | output | 1 | One-cycle result pulse |
| done_status | output | 8 | Status byte read from the device |
| done_fail | output | 1 | Status bit 0 was set |
| done_mismatch | output | 1 | Request refused for plane/die bit mismatch |
| done_timeout | output | 1 | A busy wait expired |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq_out | output | 8 | Command/address byte to the pads |
| dq_oe | output | 1 | Pad output enable |
| dq_in | input | 8 | Byte from the pads |
| rb | input | 1 | Ready/busy from the device, high when ready |
| pp_check | input | 1 | Query: a partial-page program is about to target `pp_row` |
| pp_row | input | 24 | Row address of the queried program |
| pp_locked | output | 1 | Query hits a locked block |
| erase_note | input | 1 | Pulse: the block holding `erase_row` was erased |
| erase_row | input | 24 | Any row inside the erased block |

## Verification
The hardest states to reach are the two timeout exits, because a well-behaved device always returns to ready. The bench's device model can be told to hold ready/busy low after the read phase or after the confirm byte. This drives the sequencer into each expiry path separately, and the bench counts exactly how many bytes were written before the abort. The ignored-start case is reached by pulsing a second request with different addresses in the middle of the first wait, then comparing every logged bus byte against the first request's addresses.

// File: rtl/nand_cb_pkg.sv
package nand_cb_pkg;

    localparam int ROW_MAX = 24;

    localparam logic [7:0] OP_READ    = 8'h00;
    localparam logic [7:0] OP_COPY    = 8'h8A;
    localparam logic [7:0] OP_CONFIRM = 8'h10;
    localparam logic [7:0] OP_STATUS  = 8'h70;

    typedef enum logic [2:0] {
        DEN_128M,
        DEN_256M,
        DEN_512M,
        DEN_512M_DUAL,
        DEN_1G_DUAL
    } density_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RCMD,
        S_RADR,
        S_RWAIT,
        S_PCMD,
        S_PADR,
        S_CFM,
        S_PWAIT,
        S_SCMD,
        S_SRD,
        S_DONE
    } seq_state_e;

    typedef struct packed {
        logic [7:0] status;
        logic       fail;
        logic       mismatch;
        logic       timeout;
    } cb_result_t;

    // Row bit k carries device address bit A(k+9).
    function automatic logic [ROW_MAX-1:0] plane_mask(density_e d);
        logic [ROW_MAX-1:0] m;
        m = '0;
        case (d)
            DEN_128M:      m[14] = 1'b1;
            DEN_256M:      m[15] = 1'b1;
            DEN_512M:      m[16] = 1'b1;
            DEN_512M_DUAL: begin m[15] = 1'b1; m[16] = 1'b1; end
            DEN_1G_DUAL:   begin m[16] = 1'b1; m[17] = 1'b1; end
            default:       m = '0;
        endcase
        return m;
    endfunction

    function automatic logic [7:0] addr_byte(logic [ROW_MAX-1:0] row, logic [1:0] idx);
        case (idx)
            2'd1:    return row[7:0];
            2'd2:    return row[15:8];
            2'd3:    return row[23:16];
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/nand_cb_strobe.sv
module nand_cb_strobe #(
    parameter int LOW_CYC  = 2,
    parameter int HIGH_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic strobe_n,
    output logic sample,
    output logic fin
);
    localparam int MAXC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int CW   = $clog2(MAXC + 1) + 1;

    typedef enum logic [1:0] {P_IDLE, P_LOW, P_HIGH} phase_e;
    phase_e         ph;
    logic [CW-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= P_IDLE;
            cnt <= '0;
        end else begin
            unique case (ph)
                P_IDLE: if (go) begin
                    ph  <= P_LOW;
                    cnt <= CW'(LOW_CYC - 1);
                end
                P_LOW: if (cnt == '0) begin
                    ph  <= P_HIGH;
                    cnt <= CW'(HIGH_CYC - 1);
                end else begin
                    cnt <= cnt - 1'b1;
                end
                P_HIGH: if (cnt == '0) begin
                    ph <= P_IDLE;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: ph <= P_IDLE;
            endcase
        end
    end

    assign strobe_n = (ph != P_LOW);
    assign sample   = (ph == P_LOW)  && (cnt == '0);
    assign fin      = (ph == P_HIGH) && (cnt == '0);
endmodule

// File: rtl/nand_cb_busywait.sv
module nand_cb_busywait #(
    parameter int GUARD = 8,
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic rb,
    output logic ready,
    output logic expired
);
    localparam int MAXC = (GUARD > LIMIT) ? GUARD : LIMIT;
    localparam int CW   = $clog2(MAXC + 1) + 1;
    localparam logic [CW-1:0] G_END = CW'(GUARD - 1);
    localparam logic [CW-1:0] L_END = CW'(LIMIT - 1);

    typedef enum logic [1:0] {W_IDLE, W_GUARD, W_POLL} wphase_e;
    wphase_e        ph;
    logic [CW-1:0]  cnt;
    logic [1:0]     rb_sync;

    always_ff @(posedge clk) begin
        if (rst) rb_sync <= 2'b11;
        else     rb_sync <= {rb_sync[0], rb};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= W_IDLE;
            cnt <= '0;
        end else begin
            unique case (ph)
                W_IDLE: if (go) begin
                    ph  <= W_GUARD;
                    cnt <= '0;
                end
                W_GUARD: if (cnt == G_END) begin
                    ph  <= W_POLL;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                W_POLL: if (rb_sync[1] || cnt == L_END) begin
                    ph  <= W_IDLE;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: ph <= W_IDLE;
            endcase
        end
    end

    assign ready   = (ph == W_POLL) && rb_sync[1];
    assign expired = (ph == W_POLL) && !rb_sync[1] && (cnt == L_END);
endmodule

// File: rtl/nand_cb_lockout.sv
module nand_cb_lockout #(
    parameter int ROW_W     = 24,
    parameter int PAGE_BITS = 5,
    parameter int DEPTH     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rec,
    input  logic [ROW_W-1:0] rec_row,
    input  logic             clr,
    input  logic [ROW_W-1:0] clr_row,
    input  logic [ROW_W-1:0] q_row,
    output logic             hit
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [ROW_W-1:0] BMASK = ~((ROW_W'(1) << PAGE_BITS) - ROW_W'(1));

    logic [ROW_W-1:0] blk [DEPTH];
    logic [DEPTH-1:0] vld, q_match, c_match;
    logic [PW-1:0]    ptr;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign q_match[g] = vld[g] && (blk[g] == (q_row & BMASK));
        assign c_match[g] = vld[g] && (blk[g] == (clr_row & BMASK));

        always_ff @(posedge clk) begin
            if (rst) begin
                vld[g] <= 1'b0;
                blk[g] <= '0;
            end else if (rec && ptr == PW'(g)) begin
                vld[g] <= 1'b1;
                blk[g] <= rec_row & BMASK;
            end else if (clr && c_match[g]) begin
                vld[g] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      ptr <= '0;
        else if (rec) ptr <= (ptr == PW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
    end

    assign hit = |q_match;
endmodule

// File: rtl/nand_copyback_seq.sv
module nand_copyback_seq
    import nand_cb_pkg::*;
#(
    parameter density_e DENSITY      = DEN_1G_DUAL,
    parameter int       STROBE_LOW   = 2,
    parameter int       STROBE_HIGH  = 2,
    parameter int       WB_GUARD     = 8,
    parameter int       BUSY_TIMEOUT = 4096,
    parameter int       PAGE_BITS    = 5,
    parameter int       LOCK_DEPTH   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [ROW_MAX-1:0] src_row,
    input  logic [ROW_MAX-1:0] tgt_row,
    output logic               seq_busy,
    output logic               done,
    output logic [7:0]         done_status,
    output logic               done_fail,
    output logic               done_mismatch,
    output logic               done_timeout,
    output logic               ce_n,
    output logic               cle,
    output logic               ale,
    output logic               we_n,
    output logic               re_n,
    output logic [7:0]         dq_out,
    output logic               dq_oe,
    input  logic [7:0]         dq_in,
    input  logic               rb,
    input  logic               pp_check,
    input  logic [ROW_MAX-1:0] pp_row,
    output logic               pp_locked,
    input  logic               erase_note,
    input  logic [ROW_MAX-1:0] erase_row
);
    localparam logic [ROW_MAX-1:0] MASK = plane_mask(DENSITY);

    seq_state_e         state, step_next;
    logic               launched;
    logic [1:0]         adr_idx;
    logic [ROW_MAX-1:0] src_q, tgt_q;
    cb_result_t         res;

    logic wr_state, rd_state, wait_state;
    logic st_go, st_n, st_sample, st_fin;
    logic w_go, w_ready, w_expired;
    logic plane_diff, lock_rec, lock_hit;

    assign plane_diff = |((src_row ^ tgt_row) & MASK);

    assign cle = (state == S_RCMD) || (state == S_PCMD) ||
                 (state == S_CFM)  || (state == S_SCMD);
    assign ale = (state == S_RADR) || (state == S_PADR);
    assign wr_state   = cle || ale;
    assign rd_state   = (state == S_SRD);
    assign wait_state = (state == S_RWAIT) || (state == S_PWAIT);

    assign st_go = (wr_state || rd_state) && !launched;
    assign w_go  = wait_state && !launched;

    always_comb begin
        unique case (state)
            S_RCMD:  step_next = S_RADR;
            S_RADR:  step_next = S_RWAIT;
            S_RWAIT: step_next = S_PCMD;
            S_PCMD:  step_next = S_PADR;
            S_PADR:  step_next = S_CFM;
            S_CFM:   step_next = S_PWAIT;
            S_PWAIT: step_next = S_SCMD;
            S_SCMD:  step_next = S_SRD;
            S_SRD:   step_next = S_DONE;
            default: step_next = S_IDLE;
        endcase
    end

    always_comb begin
        unique case (state)
            S_RCMD:  dq_out = OP_READ;
            S_PCMD:  dq_out = OP_COPY;
            S_CFM:   dq_out = OP_CONFIRM;
            S_SCMD:  dq_out = OP_STATUS;
            S_RADR:  dq_out = addr_byte(src_q, adr_idx);
            S_PADR:  dq_out = addr_byte(tgt_q, adr_idx);
            default: dq_out = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            launched <= 1'b0;
            adr_idx  <= '0;
            src_q    <= '0;
            tgt_q    <= '0;
            res      <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    src_q    <= src_row;
                    tgt_q    <= tgt_row;
                    res      <= '0;
                    launched <= 1'b0;
                    adr_idx  <= '0;
                    if (plane_diff) begin
                        res.mismatch <= 1'b1;
                        state        <= S_DONE;
                    end else begin
                        state <= S_RCMD;
                    end
                end
                S_RWAIT, S_PWAIT: begin
                    if (!launched) begin
                        launched <= 1'b1;
                    end else if (w_ready) begin
                        launched <= 1'b0;
                        state    <= step_next;
                    end else if (w_expired) begin
                        launched    <= 1'b0;
                        res.timeout <= 1'b1;
                        state       <= S_DONE;
                    end
                end
                S_DONE: state <= S_IDLE;
                default: begin
                    if (rd_state && st_sample) begin
                        res.status <= dq_in;
                        res.fail   <= dq_in[0];
                    end
                    if (!launched) begin
                        launched <= 1'b1;
                    end else if (st_fin) begin
                        launched <= 1'b0;
                        if (ale && adr_idx != 2'd3) begin
                            adr_idx <= adr_idx + 1'b1;
                        end else begin
                            adr_idx <= '0;
                            state   <= step_next;
                        end
                    end
                end
            endcase
        end
    end

    nand_cb_strobe #(
        .LOW_CYC  (STROBE_LOW),
        .HIGH_CYC (STROBE_HIGH)
    ) i_strobe (
        .clk      (clk),
        .rst      (rst),
        .go       (st_go),
        .strobe_n (st_n),
        .sample   (st_sample),
        .fin      (st_fin)
    );

    nand_cb_busywait #(
        .GUARD (WB_GUARD),
        .LIMIT (BUSY_TIMEOUT)
    ) i_wait (
        .clk     (clk),
        .rst     (rst),
        .go      (w_go),
        .rb      (rb),
        .ready   (w_ready),
        .expired (w_expired)
    );

    assign lock_rec = (state == S_DONE) && !res.fail && !res.mismatch && !res.timeout;

    nand_cb_lockout #(
        .ROW_W     (ROW_MAX),
        .PAGE_BITS (PAGE_BITS),
        .DEPTH     (LOCK_DEPTH)
    ) i_lock (
        .clk     (clk),
        .rst     (rst),
        .rec     (lock_rec),
        .rec_row (tgt_q),
        .clr     (erase_note),
        .clr_row (erase_row),
        .q_row   (pp_row),
        .hit     (lock_hit)
    );

    assign pp_locked     = pp_check && lock_hit;
    assign ce_n          = (state == S_IDLE) || (state == S_DONE);
    assign we_n          = wr_state ? st_n : 1'b1;
    assign re_n          = rd_state ? st_n : 1'b1;
    assign dq_oe         = wr_state;
    assign seq_busy      = (state != S_IDLE);
    assign done          = (state == S_DONE);
    assign done_status   = res.status;
    assign done_fail     = res.fail;
    assign done_mismatch = res.mismatch;
    assign done_timeout  = res.timeout;
endmodule

// File: rtl/nand_cb_checker.sv
module nand_cb_checker #(
    parameter int WE_LOW = 2
) (
    input logic clk,
    input logic rst,
    input logic seq_busy,
    input logic done,
    input logic done_fail,
    input logic done_mismatch,
    input logic done_timeout,
    input logic ce_n,
    input logic cle,
    input logic ale,
    input logic we_n,
    input logic re_n
);
    logic [15:0] lowrun;

    always_ff @(posedge clk) begin
        if (rst)        lowrun <= '0;
        else if (!we_n) lowrun <= lowrun + 1'b1;
        else            lowrun <= '0;
    end

    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (rst) !(cle && ale)); // R6
    AST_CE_ON_STROBE: assert property (@(posedge clk) disable iff (rst) (!we_n || !re_n) |-> !ce_n); // R6
    AST_WE_WIDTH: assert property (@(posedge clk) disable iff (rst) $rose(we_n) |-> lowrun == 16'(WE_LOW)); // R6
    AST_NO_RE_WITH_WE: assert property (@(posedge clk) disable iff (rst) !(!we_n && !re_n)); // R5
    AST_REJECT_NO_BUS: assert property (@(posedge clk) disable iff (rst) (done && done_mismatch) |-> ($past(ce_n) && ce_n)); // R7
    AST_TIMEOUT_QUIET: assert property (@(posedge clk) disable iff (rst) (done && done_timeout) |-> (we_n && re_n && !done_fail)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R9
    AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (rst) done |-> $onehot0({done_fail, done_mismatch, done_timeout})); // R9
    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (rst) (seq_busy && !done) |=> seq_busy); // R10
endmodule

bind nand_copyback_seq nand_cb_checker #(.WE_LOW(STROBE_LOW)) i_chk (
    .clk           (clk),
    .rst           (rst),
    .seq_busy      (seq_busy),
    .done          (done),
    .done_fail     (done_fail),
    .done_mismatch (done_mismatch),
    .done_timeout  (done_timeout),
    .ce_n          (ce_n),
    .cle           (cle),
    .ale           (ale),
    .we_n          (we_n),
    .re_n          (re_n)
);

// File: tb/test_nand_copyback_seq.sv
`timescale 1ns/1ps
module test_nand_copyback_seq;
    localparam int READ_BUSY = 30;
    localparam int PROG_BUSY = 60;
    localparam int TO_LIM    = 300;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [23:0] src_row = '0, tgt_row = '0, pp_row = '0, erase_row = '0;
    logic pp_check = 1'b0, erase_note = 1'b0;
    logic seq_busy, done, done_fail, done_mismatch, done_timeout;
    logic [7:0] done_status, dq_out, dq_in;
    logic ce_n, cle, ale, we_n, re_n, dq_oe, rb, pp_locked;

    always #2 clk = ~clk;

    nand_copyback_seq #(.BUSY_TIMEOUT(TO_LIM)) i_nand_copyback_seq (
        .clk(clk), .rst(rst), .start(start), .src_row(src_row), .tgt_row(tgt_row),
        .seq_busy(seq_busy), .done(done), .done_status(done_status), .done_fail(done_fail),
        .done_mismatch(done_mismatch), .done_timeout(done_timeout), .ce_n(ce_n), .cle(cle),
        .ale(ale), .we_n(we_n), .re_n(re_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in),
        .rb(rb), .pp_check(pp_check), .pp_row(pp_row), .pp_locked(pp_locked),
        .erase_note(erase_note), .erase_row(erase_row)
    );

    int n_chk = 0, n_err = 0;

    // device model
    logic       model_rst = 1'b0, hang_rd = 1'b0, hang_pg = 1'b0;
    logic [7:0] st_val = 8'hC0;
    logic       we_q = 1'b1, re_q = 1'b1, ce_q = 1'b1;
    logic [7:0] ev_b [0:31];
    logic       ev_c [0:31];
    int         ev_t [0:31];
    int n_ev = 0, cyc = 0, busy_cnt = 0, adr_n = 0, rd_end = 0, pg_end = 0;
    int re_falls = 0, ce_rises = 0, done_cnt = 0, cur_low = 0, first_low = 0;
    logic rd_mode = 1'b0, busy_rd = 1'b0;

    assign rb    = (busy_cnt == 0);
    assign dq_in = re_n ? 8'h00 : st_val;

    always @(posedge clk) begin
        cyc++;
        if (model_rst) begin
            n_ev = 0; busy_cnt = 0; adr_n = 0; rd_mode = 0; re_falls = 0;
            ce_rises = 0; done_cnt = 0; cur_low = 0; first_low = 0; rd_end = 0; pg_end = 0;
        end else begin
            if (done === 1'b1) done_cnt++;
            if (re_q === 1'b1 && re_n === 1'b0) re_falls++;
            if (ce_q === 1'b0 && ce_n === 1'b1) ce_rises++;
            if (we_n === 1'b0) cur_low++;
            if (busy_cnt > 0) begin
                busy_cnt--;
                if (busy_cnt == 0) begin
                    if (busy_rd) rd_end = cyc; else pg_end = cyc;
                end
            end
            if (we_q === 1'b0 && we_n === 1'b1) begin
                if (n_ev == 0) first_low = cur_low;
                if (n_ev < 32) begin
                    ev_b[n_ev] = dq_out; ev_c[n_ev] = cle; ev_t[n_ev] = cyc;
                end
                n_ev++;
                if (cle && dq_out == 8'h00) begin rd_mode = 1; adr_n = 0; end
                else if (ale && rd_mode) begin
                    adr_n++;
                    if (adr_n == 4) begin
                        rd_mode = 0; busy_rd = 1;
                        busy_cnt = hang_rd ? 100000 : READ_BUSY;
                    end
                end else if (cle && dq_out == 8'h10) begin
                    busy_rd = 0;
                    busy_cnt = hang_pg ? 100000 : PROG_BUSY;
                end
            end
            if (we_n === 1'b1) cur_low = 0;
        end
        we_q = we_n; re_q = re_n; ce_q = ce_n;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [8:0] exp_ev(input int i, input logic [23:0] s, input logic [23:0] t);
        case (i)
            0:  return {1'b1, 8'h00};
            1:  return {1'b0, 8'h00};
            2:  return {1'b0, s[7:0]};
            3:  return {1'b0, s[15:8]};
            4:  return {1'b0, s[23:16]};
            5:  return {1'b1, 8'h8A};
            6:  return {1'b0, 8'h00};
            7:  return {1'b0, t[7:0]};
            8:  return {1'b0, t[15:8]};
            9:  return {1'b0, t[23:16]};
            10: return {1'b1, 8'h10};
            default: return {1'b1, 8'h70};
        endcase
    endfunction

    task automatic check_events(input logic [23:0] s, input logic [23:0] t, input int lo, input int hi, input string req);
        int bad = -1;
        for (int i = lo; i < hi; i++)
            if ({ev_c[i], ev_b[i]} !== exp_ev(i, s, t) && bad < 0) bad = i;
        if (bad < 0) chk(1'b1, req, "bytes", 0, 0);
        else chk(1'b0, req, $sformatf("byte %0d", bad), {ev_c[bad], ev_b[bad]}, exp_ev(bad, s, t));
    endtask

    logic [7:0] r_status;
    logic r_fail, r_mm, r_to, r_got;
    int r_lat;

    task automatic run_copy(input logic [23:0] s, input logic [23:0] t, input bit extra);
        @(negedge clk); model_rst = 1'b1;
        @(negedge clk); model_rst = 1'b0;
        start = 1'b1; src_row = s; tgt_row = t;
        @(negedge clk); start = 1'b0;
        r_got = 1'b0; r_lat = 0;
        for (int k = 0; k < 5000; k++) begin
            if (done) begin
                r_got = 1'b1; r_lat = k; r_status = done_status;
                r_fail = done_fail; r_mm = done_mismatch; r_to = done_timeout;
                break;
            end
            if (extra && k == 20) begin
                start = 1'b1; src_row = 24'h020000; tgt_row = 24'h020001;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        repeat (4) @(negedge clk);
        chk(r_got, "R9", "done seen", r_got, 1);
        chk(done_cnt == 1, "R9", "done count", done_cnt, 1);
    endtask

    task automatic pp_probe(input logic [23:0] row, input bit exp, input string req);
        @(negedge clk); pp_check = 1'b1; pp_row = row;
        #1;
        chk(pp_locked === exp, req, "pp_locked", pp_locked, exp);
        @(negedge clk); pp_check = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(ce_n && we_n && re_n && !cle && !ale && !done && !seq_busy, "R1", "in reset", {ce_n, we_n, re_n, cle, ale, done}, 6'b111000);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(ce_n && we_n && re_n && !cle && !ale && !done && !seq_busy, "R1", "after reset", {ce_n, we_n, re_n, cle, ale, done}, 6'b111000);
    endtask

    task automatic t_normal;
        st_val = 8'hC0;
        run_copy(24'h023445, 24'h029A20, 1'b0);
        chk(n_ev == 12, "R2", "byte count", n_ev, 12);
        check_events(24'h023445, 24'h029A20, 0, 5, "R2");
        check_events(24'h023445, 24'h029A20, 5, 11, "R4");
        check_events(24'h023445, 24'h029A20, 11, 12, "R5");
        chk(ev_t[5] > rd_end && rd_end > 0, "R3", "8A after ready", ev_t[5], rd_end);
        chk(ev_t[11] > pg_end && pg_end > 0, "R5", "70 after ready", ev_t[11], pg_end);
        chk(re_falls == 1, "R5", "read strobes", re_falls, 1);
        chk(r_status == 8'hC0 && !r_fail && !r_mm && !r_to, "R5", "status pass", {r_status, r_fail, r_mm, r_to}, 11'h600);
        chk(first_low == 2, "R6", "we_n low width", first_low, 2);
        chk(ce_rises == 1, "R6", "ce_n rises", ce_rises, 1);
        pp_probe(24'h029A20, 1'b1, "R11");
        pp_probe(24'h029A3F, 1'b1, "R11");
        pp_probe(24'h029A40, 1'b0, "R11");
    endtask

    task automatic t_ignore;
        run_copy(24'h031111, 24'h03C000, 1'b1);
        chk(n_ev == 12, "R10", "byte count", n_ev, 12);
        check_events(24'h031111, 24'h03C000, 0, 12, "R10");
        pp_probe(24'h03C000, 1'b1, "R11");
    endtask

    task automatic t_fail;
        st_val = 8'hC1;
        run_copy(24'h011111, 24'h010400, 1'b0);
        chk(r_fail && r_status == 8'hC1 && !r_to && !r_mm, "R5", "status fail", {r_status, r_fail}, 9'h183);
        pp_probe(24'h010400, 1'b0, "R12");
        st_val = 8'hC0;
    endtask

    task automatic t_mismatch;
        run_copy(24'h010040, 24'h000080, 1'b0);
        chk(r_mm && !r_fail && !r_to, "R7", "mismatch flag", {r_mm, r_fail, r_to}, 3'b100);
        chk(r_lat <= 1, "R7", "latency", r_lat, 1);
        chk(n_ev == 0 && ce_rises == 0, "R7", "bus untouched", n_ev + ce_rises, 0);
        pp_probe(24'h000080, 1'b0, "R12");
    endtask

    task automatic t_timeouts;
        hang_rd = 1'b1;
        run_copy(24'h001000, 24'h002000, 1'b0);
        hang_rd = 1'b0;
        chk(r_to && !r_fail && !r_mm, "R8", "timeout read wait", {r_to, r_fail, r_mm}, 3'b100);
        chk(n_ev == 5, "R8", "bytes before abort 1", n_ev, 5);
        chk(ce_n && ce_rises == 1, "R8", "ce released", ce_rises, 1);
        hang_pg = 1'b1;
        run_copy(24'h001000, 24'h002000, 1'b0);
        hang_pg = 1'b0;
        chk(r_to && !r_fail, "R8", "timeout program wait", {r_to, r_fail}, 2'b10);
        chk(n_ev == 11 && re_falls == 0, "R8", "bytes before abort 2", n_ev, 11);
        pp_probe(24'h002000, 1'b0, "R12");
    endtask

    task automatic t_erase;
        @(negedge clk); erase_note = 1'b1; erase_row = 24'h029A25;
        @(negedge clk); erase_note = 1'b0;
        pp_probe(24'h029A20, 1'b0, "R12");
        pp_probe(24'h03C000, 1'b1, "R12");
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        t_reset;
        t_normal;
        t_ignore;
        t_fail;
        t_mismatch;
        t_timeouts;
        t_erase;
        summary;
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual %0d expected 0", 1);
        summary;
    end
endmodule